// File: doc/BRIEF.md
# Bitplane Fetch Window Controller

This block decides, cycle by cycle along a scanline, when bitplane memory fetches may run. It watches a horizontal beam position and compares it against two programmable positions, a start and a stop, that software writes through a small register port. Each written position is kept internally four cycles early, so a compare match at that early position makes the start or stop take effect exactly four cycles later, at the written position. The fetch window is also held inside a hard window that can be widened by a limits-disable input.

Once fetching runs, a counter numbers the fetch cycles, and the window never closes mid-block: after the stop takes effect the block waits for the next fetch-unit boundary, runs one more full unit and then reports the line as done. Writes that land on the very cycle of a compare match cancel that match. A stop that is never reached before the hard stop is forced there; in enhanced mode that event is remembered and the next line begins fetching right at its start. A legacy mode changes the write masking and how the window is armed.

Top module: `fetch_window`

## Requirements
- R1: A write keeps bits 7..1 of the data in enhanced mode (`enh_mode`=1) and bits 7..2 in legacy mode; `wr_stop`=0 selects the start position, 1 the stop position.
- R2: With DMA on, `fetch_active` goes high after the clock edge at which `hpos` equals the written start value (compare at start−4, effect 4 cycles later).
- R3: The fetch unit is 4<<`unit_sel` cycles (0:4, 1:8, 2:16). The stop takes effect at the written stop value S; fetching then continues to the first position B ≥ S with (B−start) a multiple of the unit, plus one more unit; `fetch_active` falls and `line_done` rises after the edge at B+unit.
- R4: `fetch_cnt` reads 1 after the first active edge and rises by one on each further active cycle, so at `line_done` it equals the number of cycles fetched, a multiple of the unit.
- R5: In enhanced mode the window arms at the internal start position whether DMA is on or not, and a line run with DMA off still ends with `line_done` but never raises `fetch_active`; in legacy mode it arms only at position 0x14 while DMA is on, and if DMA is off there the whole line stays idle.
- R6: A start write on the exact cycle where the old start would match cancels that start; fetching begins from the newly written start instead.
- R7: A stop write on a cycle where the old or the new internal stop equals `hpos` suppresses the stop match on that cycle.
- R8: If the programmed stop has not matched by the hard stop (0xD4, or 0xFF with `lim_off`), the stop is forced there; in enhanced mode the next line fetches from its first cycle, in legacy mode it does not.
- R9: In enhanced mode the internal start is raised at line start to at least the hard start (0x14, or 0x04 with `lim_off`), and fetching cannot begin before 0x18 unless `lim_off` is set.
- R10: In enhanced mode, if the internal stop exceeds `line_len` at line start, the start is forced to the hard start (always-on display).
- R11: On a line flagged `last_line` fetching never starts; `line_done` rises after the edge at the written start.
- R12: A line start returns a finished line to idle, so `line_done` is low after the line-start edge.
- R13: After reset `fetch_active` and `line_done` are low and `fetch_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one beam position per cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| hpos | input | 9 | Horizontal beam position |
| line_len | input | 9 | Positions per scanline |
| line_start | input | 1 | High on the first cycle of a line |
| last_line | input | 1 | Current line is the last of the vertical window |
| dma_en | input | 1 | Bitplane DMA enabled |
| enh_mode | input | 1 | 1 enhanced mode, 0 legacy mode |
| lim_off | input | 1 | Widens the hard window to 0x04..0xFF |
| unit_sel | input | 2 | Fetch unit size select |
| wr_en | input | 1 | Position register write strobe |
| wr_stop | input | 1 | Write target: 0 start, 1 stop |
| wr_data | input | 8 | Written position |
| fetch_active | output | 1 | Fetch cycles are running |
| fetch_cnt | output | 8 | Fetch cycle count since activation |
| line_done | output | 1 | Last block of the line completed |

## Verification
The hardest situations to reach are the match-cycle writes and the hard-stop carry-over, since each needs a write on one exact beam position or a stop that is never reached. The stimulus walks a full line position by position and issues a single write at a chosen position: on the old start match, on the old stop match, and on a cycle equal to the newly written stop, which also leaves the stop unreachable and forces the hard stop. The following line is then run without reset to show the carried-over early start in enhanced mode and its absence in legacy mode.

// File: rtl/fetch_window.sv
module fetch_window #(
  parameter int POS_W = 9,
  parameter int CNT_W = 8,
  parameter int DLY = 4,
  parameter logic [POS_W-1:0] HARD_LO = 9'h014,
  parameter logic [POS_W-1:0] HARD_HI = 9'h0D4,
  parameter logic [POS_W-1:0] FREE_LO = 9'h004,
  parameter logic [POS_W-1:0] FREE_HI = 9'h0FF
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [POS_W-1:0] hpos,
  input  logic [POS_W-1:0] line_len,
  input  logic             line_start,
  input  logic             last_line,
  input  logic             dma_en,
  input  logic             enh_mode,
  input  logic             lim_off,
  input  logic [1:0]       unit_sel,
  input  logic             wr_en,
  input  logic             wr_stop,
  input  logic [7:0]       wr_data,
  output logic             fetch_active,
  output logic [CNT_W-1:0] fetch_cnt,
  output logic             line_done
);

  localparam logic [POS_W-1:0] DLY_P    = POS_W'(DLY);
  localparam logic [POS_W-1:0] PARK_POS = POS_W'(256 + DLY);
  localparam logic [POS_W-1:0] NEVER    = {POS_W{1'b1}};

  typedef enum logic [3:0] {
    S_IDLE, S_ARMED, S_STARTED, S_ACTIVE, S_OPEN, S_OPEN_STOP,
    S_STOP, S_STOP_EFF, S_LAST, S_END
  } st_t;

  st_t st_q, sn;
  logic [POS_W-1:0] strt_q, strt_n, stop_q, stop_n;
  logic [POS_W-1:0] spend_q, spend_n, epend_q, epend_n;
  logic             carry_q, carry_n, restart;
  logic [CNT_W-1:0] cnt_q, cnt_n, unit_mask;
  logic [POS_W-1:0] hard_lo, hard_hi, arm_pos, wr_int, base;
  logic [7:0]       wr_m;
  logic             go, strt_wr, stop_wr, start_cancel, stop_block, open_ok, on_bound;

  assign hard_lo      = lim_off ? FREE_LO : HARD_LO;
  assign hard_hi      = lim_off ? FREE_HI : HARD_HI;
  assign unit_mask    = (CNT_W'(4) << unit_sel) - CNT_W'(1);
  assign wr_m         = wr_data & (enh_mode ? 8'hFE : 8'hFC);
  assign wr_int       = POS_W'(wr_m) - DLY_P;
  assign strt_wr      = wr_en && !wr_stop;
  assign stop_wr      = wr_en && wr_stop;
  assign go           = dma_en || enh_mode;
  assign arm_pos      = enh_mode ? strt_q : HARD_LO;
  assign start_cancel = strt_wr && (hpos == strt_q);
  assign stop_block   = stop_wr && ((hpos == stop_q) || (hpos == wr_int));
  assign open_ok      = !enh_mode || lim_off || (hpos >= hard_lo + DLY_P);
  assign on_bound     = (cnt_q & unit_mask) == '0;

  function automatic logic counting(st_t s);
    return s inside {S_ACTIVE, S_OPEN, S_OPEN_STOP, S_STOP, S_STOP_EFF, S_LAST};
  endfunction

  always_comb begin
    sn      = st_q;
    strt_n  = strt_q;
    stop_n  = stop_q;
    spend_n = spend_q;
    epend_n = epend_q;
    carry_n = carry_q;
    restart = 1'b0;
    base    = strt_q;

    if (line_start) begin
      if (st_q >= S_LAST) sn = S_IDLE;
      spend_n = PARK_POS;
      epend_n = PARK_POS;
      if (enh_mode) begin
        base   = (stop_q > line_len) ? '0 : strt_q;
        strt_n = (base < hard_lo) ? hard_lo : base;
        if (carry_q) begin
          carry_n = 1'b0;
          if (!last_line) begin
            sn      = dma_en ? S_ACTIVE : S_OPEN;
            restart = 1'b1;
          end
        end
      end
    end else begin
      if (go && hpos == arm_pos && (sn == S_IDLE || sn >= S_LAST))
        sn = S_ARMED;

      if (go && hpos == strt_q && sn == S_ARMED) begin
        if (start_cancel) spend_n = line_len;
        else begin
          sn      = S_STARTED;
          spend_n = hpos + DLY_P;
        end
      end

      if (sn == S_STARTED && hpos == spend_q) begin
        restart = !last_line;
        if (last_line)             sn = S_END;
        else if (dma_en && open_ok) sn = S_ACTIVE;
        else                       sn = S_OPEN;
      end else if (sn == S_OPEN && dma_en && open_ok && !last_line) begin
        sn = S_ACTIVE;
      end else if (sn == S_ACTIVE && !dma_en) begin
        sn = S_OPEN;
      end

      if (hpos == stop_q && !stop_block && (sn == S_ACTIVE || sn == S_OPEN)) begin
        sn      = (sn == S_OPEN) ? S_OPEN_STOP : S_STOP;
        epend_n = hpos + DLY_P;
      end else if (hpos == epend_q && (sn == S_STOP || sn == S_OPEN_STOP)) begin
        sn = S_STOP_EFF;
      end

      if (hpos == hard_hi && sn >= S_ACTIVE && sn < S_STOP_EFF) begin
        if (enh_mode && (sn == S_ACTIVE || sn == S_OPEN)) carry_n = 1'b1;
        sn = S_STOP_EFF;
      end

      if (on_bound && !restart) begin
        if (sn == S_LAST)          sn = S_END;
        else if (sn == S_STOP_EFF) sn = S_LAST;
      end
    end

    if (strt_wr) strt_n = wr_int;
    if (stop_wr) stop_n = wr_int;

    if (restart)           cnt_n = CNT_W'(1);
    else if (counting(sn)) cnt_n = cnt_q + CNT_W'(1);
    else                   cnt_n = cnt_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      strt_q  <= NEVER;
      stop_q  <= NEVER;
      spend_q <= PARK_POS;
      epend_q <= PARK_POS;
      carry_q <= 1'b0;
      cnt_q   <= '0;
    end else begin
      st_q    <= sn;
      strt_q  <= strt_n;
      stop_q  <= stop_n;
      spend_q <= spend_n;
      epend_q <= epend_n;
      carry_q <= carry_n;
      cnt_q   <= cnt_n;
    end
  end

  assign fetch_active = dma_en && (st_q inside {S_ACTIVE, S_STOP, S_STOP_EFF, S_LAST});
  assign fetch_cnt    = cnt_q;
  assign line_done    = st_q == S_END;

endmodule

// File: rtl/fetch_window_chk.sv
module fetch_window_chk #(
  parameter int POS_W = 9,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             line_start,
  input logic             last_line,
  input logic [1:0]       unit_sel,
  input logic             fetch_active,
  input logic [CNT_W-1:0] fetch_cnt,
  input logic             line_done
);

  logic [CNT_W-1:0] mask;
  assign mask = (CNT_W'(4) << unit_sel) - CNT_W'(1);

  p_end_aligned_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(line_done) && $past(fetch_active)) |-> ((fetch_cnt & mask) == '0));

  p_cnt_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_active && $past(fetch_active) && !$past(line_start))
      |-> (fetch_cnt == $past(fetch_cnt) + CNT_W'(1)));

  p_no_fetch_last_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_active) |-> !$past(last_line));

  p_done_cleared_r12: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(line_start) && $past(line_done)) |-> !line_done);

endmodule

bind fetch_window fetch_window_chk #(.POS_W(POS_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .line_start(line_start), .last_line(last_line),
  .unit_sel(unit_sel), .fetch_active(fetch_active), .fetch_cnt(fetch_cnt),
  .line_done(line_done)
);

// File: tb/fetch_window_tb.sv
module fetch_window_tb;
  localparam int LEN = 227;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [8:0] hpos = 9'h1F0;
  logic [8:0] line_len = 9'(LEN);
  logic line_start = 1'b0, last_line = 1'b0, dma_en = 1'b1;
  logic enh_mode = 1'b1, lim_off = 1'b0;
  logic [1:0] unit_sel = 2'd1;
  logic wr_en = 1'b0, wr_stop = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic fetch_active, line_done;
  logic [7:0] fetch_cnt;

  int n_chk = 0, n_bad = 0, cyc = 0;
  int dma_lo = 1000, dma_hi = 1000;
  int fa_on, fa_off, done_at, cnt_done, done0;

  always #10 clk = ~clk;

  fetch_window u_dut (
    .clk(clk), .rst_n(rst_n), .hpos(hpos), .line_len(line_len),
    .line_start(line_start), .last_line(last_line), .dma_en(dma_en),
    .enh_mode(enh_mode), .lim_off(lim_off), .unit_sel(unit_sel),
    .wr_en(wr_en), .wr_stop(wr_stop), .wr_data(wr_data),
    .fetch_active(fetch_active), .fetch_cnt(fetch_cnt), .line_done(line_done)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; hpos = 9'h1F0; line_start = 1'b0; wr_en = 1'b0;
    dma_lo = 1000; dma_hi = 1000; dma_en = 1'b1; last_line = 1'b0; lim_off = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic prog(input bit sel, input logic [7:0] val);
    @(negedge clk);
    hpos = 9'h1F0; line_start = 1'b0; dma_en = 1'b1;
    wr_en = 1'b1; wr_stop = sel; wr_data = val;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic run_line(input int wpos, input bit wsel, input logic [7:0] wval);
    fa_on = -1; fa_off = -1; done_at = -1; cnt_done = -1; done0 = -1;
    for (int p = 0; p < LEN; p++) begin
      @(negedge clk);
      hpos = 9'(p);
      line_start = (p == 0);
      dma_en = !(p >= dma_lo && p <= dma_hi);
      wr_en = (p == wpos); wr_stop = wsel; wr_data = wval;
      @(posedge clk);
      #1;
      if (p == 0) done0 = int'(line_done);
      if (fetch_active && fa_on < 0) fa_on = p;
      if (fa_on >= 0 && !fetch_active && fa_off < 0) fa_off = p;
      if (line_done && done_at < 0) begin done_at = p; cnt_done = int'(fetch_cnt); end
    end
    @(negedge clk);
    wr_en = 1'b0; line_start = 1'b0; hpos = 9'h1F0; dma_en = 1'b1;
  endtask

  task automatic t_reset();
    do_reset();
    @(posedge clk); #1;
    chk("R13 fetch_active", int'(fetch_active), 0);
    chk("R13 line_done", int'(line_done), 0);
    chk("R13 fetch_cnt", int'(fetch_cnt), 0);
  endtask

  task automatic t_normal();
    do_reset(); enh_mode = 1'b1; unit_sel = 2'd1;
    prog(0, 8'h38); prog(1, 8'hD0);
    run_line(-1, 0, 0);
    chk("R2 start", fa_on, 'h38);
    chk("R3 end unit8", fa_off, 'hD8);
    chk("R3 done", done_at, 'hD8);
    chk("R4 count", cnt_done, 160);
    unit_sel = 2'd2; prog(1, 8'h90);
    run_line(-1, 0, 0);
    chk("R12 done cleared at line start", done0, 0);
    chk("R3 end unit16", fa_off, 'hA8);
    chk("R4 count unit16", cnt_done, 112);
  endtask

  task automatic t_mask();
    do_reset(); enh_mode = 1'b0; unit_sel = 2'd2;
    prog(0, 8'h3A); prog(1, 8'h90);
    run_line(-1, 0, 0);
    chk("R1 legacy mask start", fa_on, 'h38);
    chk("R1 legacy end", fa_off, 'hA8);
    do_reset(); enh_mode = 1'b1; unit_sel = 2'd0;
    prog(0, 8'h3B); prog(1, 8'h92);
    run_line(-1, 0, 0);
    chk("R1 enhanced mask start", fa_on, 'h3A);
    chk("R1 enhanced end", fa_off, 'h96);
    chk("R4 count unit4", cnt_done, 92);
  endtask

  task automatic t_dma();
    do_reset(); enh_mode = 1'b1; unit_sel = 2'd2;
    prog(0, 8'h38); prog(1, 8'h90);
    dma_lo = 0; dma_hi = LEN;
    run_line(-1, 0, 0);
    chk("R5 enhanced dma off no fetch", fa_on, -1);
    chk("R5 enhanced dma off still done", done_at, 'hA8);
    do_reset(); enh_mode = 1'b0; unit_sel = 2'd2;
    prog(0, 8'h38); prog(1, 8'h90);
    dma_lo = 'h10; dma_hi = 'h16;
    run_line(-1, 0, 0);
    chk("R5 legacy not armed fetch", fa_on, -1);
    chk("R5 legacy not armed done", done_at, -1);
  endtask

  task automatic t_start_cancel();
    do_reset(); enh_mode = 1'b1; unit_sel = 2'd1;
    prog(0, 8'h38); prog(1, 8'hD0);
    run_line('h34, 0, 8'h48);
    chk("R6 cancelled start", fa_on, 'h48);
    chk("R6 end", fa_off, 'hD8);
    chk("R6 count", cnt_done, 144);
  endtask

  task automatic t_stop_write();
    do_reset(); enh_mode = 1'b1; unit_sel = 2'd1;
    prog(0, 8'h38); prog(1, 8'h80);
    run_line('h7C, 1, 8'hA0);
    chk("R7 old stop suppressed", fa_off, 'hA8);
    chk("R7 count", cnt_done, 112);
  endtask

  task automatic t_carry();
    do_reset(); enh_mode = 1'b1; unit_sel = 2'd1;
    prog(0, 8'h38); prog(1, 8'hD0);
    run_line('h5C, 1, 8'h60);
    chk("R7 new stop suppressed start", fa_on, 'h38);
    chk("R8 hard stop end", fa_off, 'hE0);
    chk("R8 hard stop count", cnt_done, 168);
    prog(1, 8'h80);
    run_line(-1, 0, 0);
    chk("R8 carried line starts at 0", fa_on, 0);
    chk("R8 carried line end", fa_off, 'h88);
    chk("R8 carried count", cnt_done, 136);
    do_reset(); enh_mode = 1'b0; unit_sel = 2'd1;
    prog(0, 8'h38); prog(1, 8'hE0);
    run_line(-1, 0, 0);
    chk("R8 legacy hard stop end", fa_off, 'hE0);
    run_line(-1, 0, 0);
    chk("R8 legacy no carry", fa_on, 'h38);
  endtask

  task automatic t_limits();
    do_reset(); enh_mode = 1'b1; unit_sel = 2'd0;
    prog(0, 8'h60); prog(1, 8'hFE);
    run_line(-1, 0, 0);
    chk("R10 always-on start", fa_on, 'h18);
    chk("R10 always-on end", fa_off, 'hD8);
    do_reset(); enh_mode = 1'b1; unit_sel = 2'd0;
    prog(0, 8'h08); prog(1, 8'h90);
    run_line(-1, 0, 0);
    chk("R9 clamped start", fa_on, 'h18);
    chk("R9 clamped end", fa_off, 'h94);
    do_reset(); enh_mode = 1'b1; unit_sel = 2'd0;
    prog(0, 8'h08); prog(1, 8'h90);
    lim_off = 1'b1;
    run_line(-1, 0, 0);
    chk("R9 limits off start", fa_on, 'h08);
    chk("R9 limits off end", fa_off, 'h94);
    lim_off = 1'b0;
  endtask

  task automatic t_last();
    do_reset(); enh_mode = 1'b1; unit_sel = 2'd2;
    prog(0, 8'h38); prog(1, 8'h90);
    last_line = 1'b1;
    run_line(-1, 0, 0);
    chk("R11 no fetch on last line", fa_on, -1);
    chk("R11 done at start", done_at, 'h38);
    last_line = 1'b0;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog (all requirements) actual=%0d expected<150000", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_normal();
    t_mask();
    t_dma();
    t_start_cancel();
    t_stop_write();
    t_carry();
    t_limits();
    t_last();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule